// File: doc/BRIEF.md
# Debug Event Status Register

This block is a 32-bit status word that collects debug events as sticky flags. Hardware raises a flag from a one-cycle event pulse, and the flag stays set until software clears it. Software clears a flag by writing a 1 to its position. A 0 in the write data, or a byte lane whose enable is low, leaves the flag as it was. If a hardware set and a software clear hit the same flag in the same cycle, the set wins, so no event is lost.

An active-low, level-sensitive unconditional-debug input is gated by an internal-debug-mode enable. When that enable is 0, the input has no effect. When it is 1, the input sets its flag on every cycle it is held. A debug-interrupt request is raised whenever the debug-enable input is 1 and any event flag is set.

A two-bit reset-cause field is written on every reset rather than cleared. A hard reset loads it with binary 10. Any other reset keeps the upper bit and zeroes the lower bit, so the upper bit shows whether a hard reset has occurred since software last cleared the field.

Bits are numbered with index 31 as the most significant. The event flags sit at fixed positions because software decodes them.

Top module: `debug_event_status`

## Requirements
- R1: After any synchronous reset (rst_n low at a clock edge), all event flags read 0. Event pulses that arrive while reset is held do not set flags.
- R2: A one-cycle pulse on an event input sets its flag, readable on rd_data_o after the next clock edge. The positions are: insn-complete 27, branch 26, interrupt 25, trap 24, insn-match0 23, insn-match1 22, data-read0 19, data-write0 18, data-read1 17, data-write1 16, return 15.
- R3: A set flag stays set until software clears it. A hardware set and a write-one-to-clear of the same flag in the same cycle leave the flag set.
- R4: A write with wr_en_i high clears every implemented flag whose data bit is 1 and whose byte lane is enabled. Lane k covers bits 8k+7..8k. Data bits that are 0, and disabled lanes, cause no change.
- R5: Bits 31, 21, 20 and 14..0 always read 0 and ignore writes.
- R6: While uncond_dbg_n_i is low and int_mode_i is 0, flag 30 is not set.
- R7: While uncond_dbg_n_i is low and int_mode_i is 1, flag 30 is set, whatever the value of dbg_en_i.
- R8: dbg_irq_o is 1 exactly when dbg_en_i is 1 and any of bits 30, 27..22 or 19..15 is 1. The reset-cause field does not affect it.
- R9: The reset-cause field is at bits 29..28. A reset with hard_rst_i high loads binary 10. A reset with hard_rst_i low keeps bit 29 and zeroes bit 28. Outside reset the field changes only through write-one-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hard_rst_i | input | 1 | The current reset is a hard reset |
| ev_insn_i | input | 1 | Instruction-complete event pulse |
| ev_branch_i | input | 1 | Branch-taken event pulse |
| ev_intr_i | input | 1 | Interrupt event pulse |
| ev_trap_i | input | 1 | Trap event pulse |
| ev_imatch0_i | input | 1 | First instruction-address match pulse |
| ev_imatch1_i | input | 1 | Second instruction-address match pulse |
| ev_drd0_i | input | 1 | First data-address match on a read |
| ev_dwr0_i | input | 1 | First data-address match on a write |
| ev_drd1_i | input | 1 | Second data-address match on a read |
| ev_dwr1_i | input | 1 | Second data-address match on a write |
| ev_return_i | input | 1 | Return event pulse |
| uncond_dbg_n_i | input | 1 | Unconditional debug request, active low, level |
| dbg_en_i | input | 1 | Debug enable |
| int_mode_i | input | 1 | Internal debug mode enable |
| wr_en_i | input | 1 | Write-one-to-clear strobe |
| wr_be_i | input | 4 | Byte-lane enables |
| wr_data_i | input | 32 | Write data; ones select bits to clear |
| rd_data_o | output | 32 | Current register value |
| dbg_irq_o | output | 1 | Debug interrupt request |

## Verification
Three situations are hard to reach from the ports. The first is a collision, where a hardware set and a clear of the same flag land in the same cycle; the bench drives an event pulse and a write of that flag's bit on the same clock edge. The second is the reset-cause field, which survives reset: the bench runs a hard reset, then a soft reset, then a clear by software, then another soft reset, and checks the field after each. The third is the byte-lane masking: the bench refills every flag before each of the sixteen lane-enable patterns and compares the result against a mask built arithmetically from the lane bits.

// File: rtl/dstat_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and bit positions for the debug event status register.
// Assumes a 32-bit word with index 31 as the most significant bit.
package dstat_pkg;
    localparam int REG_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int NUM_LANES = REG_W / BYTE_W;
    localparam int NUM_EV    = 12;

    localparam int IDX_UNCOND   = 30;
    localparam int IDX_CAUSE_HI = 29;
    localparam int IDX_CAUSE_LO = 28;

    // Event order: insn, branch, intr, trap, im0, im1, drd0, dwr0, drd1, dwr1, return, uncond
    localparam int EV_POS [NUM_EV] = '{27, 26, 25, 24, 23, 22, 19, 18, 17, 16, 15, IDX_UNCOND};

    // Build the mask of all event flag positions.
    function automatic logic [REG_W-1:0] ev_mask_f();
        logic [REG_W-1:0] m;
        m = '0;
        for (int e = 0; e < NUM_EV; e++) m[EV_POS[e]] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] EV_MASK    = ev_mask_f();
    localparam logic [REG_W-1:0] CAUSE_MASK = (REG_W'(1) << IDX_CAUSE_HI) | (REG_W'(1) << IDX_CAUSE_LO);
    localparam logic [REG_W-1:0] IMPL_MASK  = EV_MASK | CAUSE_MASK;
endpackage

// File: rtl/dstat_lane_mask.sv
`timescale 1ns/1ps
// Module: converts a byte-enabled write into a per-bit clear mask.
// Assumes REG_W is a multiple of BYTE_W. Bits outside KEEP_MASK are never cleared.
module dstat_lane_mask #(
    parameter int REG_W  = 32,
    parameter int BYTE_W = 8,
    parameter logic [REG_W-1:0] KEEP_MASK = '1
) (
    input  logic                      wr_en_i,
    input  logic [REG_W/BYTE_W-1:0]   be_i,
    input  logic [REG_W-1:0]          data_i,
    output logic [REG_W-1:0]          clr_o
);
    localparam int LANES = REG_W / BYTE_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // One lane: pass its data ones through when the write and lane are enabled.
        assign clr_o[l*BYTE_W +: BYTE_W] = (wr_en_i && be_i[l])
                                         ? (data_i[l*BYTE_W +: BYTE_W] & KEEP_MASK[l*BYTE_W +: BYTE_W])
                                         : '0;
    end
endmodule

// File: rtl/dstat_sticky.sv
`timescale 1ns/1ps
// Module: one sticky status flag. A hardware set takes priority over a software clear.
// Assumes set_i and clr_i are synchronous to clk. Reset clears the flag.
module dstat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    // Flag update: reset, else set wins, else clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_i | (q & ~clr_i);
    end

    assign q_o = q;

    assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && clr_i) |=> !q_o);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !q_o);
endmodule

// File: rtl/dstat_cause.sv
`timescale 1ns/1ps
// Module: two-bit reset-cause field that is written, not cleared, by reset.
// Assumes hard_i is valid during reset. The low bit is never set by this block.
module dstat_cause (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hard_i,
    input  logic [1:0] clr_i,
    output logic [1:0] q_o
);
    logic [1:0] q;

    // Field update: a hard reset loads 10, a soft reset keeps the hard bit, else W1C.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= {hard_i | q[1], 1'b0};
        else        q <= q & ~clr_i;
    end

    assign q_o = q;

    assert_hard_load_R9: assert property (@(posedge clk)
        (!rst_n && hard_i) |=> (q_o == 2'b10));
    assert_soft_low_R9: assert property (@(posedge clk)
        !rst_n |=> !q_o[0]);
    assert_run_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == 2'b00) |=> $stable(q_o));
endmodule

// File: rtl/debug_event_status.sv
`timescale 1ns/1ps
// Module: debug event status register. It holds sticky event flags that software clears
// by writing ones. It also gates an unconditional debug level input, keeps a reset-cause
// field across resets, and raises an interrupt request while debug is enabled and a flag is set.
// Assumes event inputs are single-cycle pulses, synchronous to clk.
module debug_event_status
    import dstat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hard_rst_i,
    input  logic                  ev_insn_i,
    input  logic                  ev_branch_i,
    input  logic                  ev_intr_i,
    input  logic                  ev_trap_i,
    input  logic                  ev_imatch0_i,
    input  logic                  ev_imatch1_i,
    input  logic                  ev_drd0_i,
    input  logic                  ev_dwr0_i,
    input  logic                  ev_drd1_i,
    input  logic                  ev_dwr1_i,
    input  logic                  ev_return_i,
    input  logic                  uncond_dbg_n_i,
    input  logic                  dbg_en_i,
    input  logic                  int_mode_i,
    input  logic                  wr_en_i,
    input  logic [NUM_LANES-1:0]  wr_be_i,
    input  logic [REG_W-1:0]      wr_data_i,
    output logic [REG_W-1:0]      rd_data_o,
    output logic                  dbg_irq_o
);
    logic [NUM_EV-1:0] ev_set;
    logic [NUM_EV-1:0] ev_q;
    logic [REG_W-1:0]  clr_mask;
    logic [1:0]        cause_q;
    logic [REG_W-1:0]  word;

    // Event set vector: pulses in fixed order; the unconditional request is gated by mode.
    always_comb begin
        ev_set = {~uncond_dbg_n_i & int_mode_i, ev_return_i, ev_dwr1_i, ev_drd1_i,
                  ev_dwr0_i, ev_drd0_i, ev_imatch1_i, ev_imatch0_i,
                  ev_trap_i, ev_intr_i, ev_branch_i, ev_insn_i};
    end

    dstat_lane_mask #(
        .REG_W    (REG_W),
        .BYTE_W   (BYTE_W),
        .KEEP_MASK(IMPL_MASK)
    ) u_mask (
        .wr_en_i (wr_en_i),
        .be_i    (wr_be_i),
        .data_i  (wr_data_i),
        .clr_o   (clr_mask)
    );

    for (genvar e = 0; e < NUM_EV; e++) begin : g_flag
        dstat_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ev_set[e]),
            .clr_i (clr_mask[EV_POS[e]]),
            .q_o   (ev_q[e])
        );
    end

    dstat_cause u_cause (
        .clk    (clk),
        .rst_n  (rst_n),
        .hard_i (hard_rst_i),
        .clr_i  (clr_mask[IDX_CAUSE_HI:IDX_CAUSE_LO]),
        .q_o    (cause_q)
    );

    // Read word assembly: flags at their positions, cause field, all else zero.
    always_comb begin
        word = '0;
        for (int e = 0; e < NUM_EV; e++) word[EV_POS[e]] = ev_q[e];
        word[IDX_CAUSE_HI:IDX_CAUSE_LO] = cause_q;
    end

    assign rd_data_o = word;
    // Interrupt request: debug enabled and any event flag held.
    assign dbg_irq_o = dbg_en_i & (|ev_q);

    assert_uncond_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!uncond_dbg_n_i && !int_mode_i && !rd_data_o[IDX_UNCOND]) |=> !rd_data_o[IDX_UNCOND]);
    assert_uncond_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!uncond_dbg_n_i && int_mode_i) |=> rd_data_o[IDX_UNCOND]);
    assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq_o |-> dbg_en_i);
    assert_rsv_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en_i) |-> ((rd_data_o & ~IMPL_MASK) == '0));
endmodule

// File: tb/debug_event_status_test.sv
`timescale 1ns/1ps
module debug_event_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hard = 1'b1;
    logic [10:0] evs = '0;
    logic        ud_n = 1'b1;
    logic        den = 1'b0;
    logic        imode = 1'b0;
    logic        wen = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    localparam int POS [11] = '{27, 26, 25, 24, 23, 22, 19, 18, 17, 16, 15};
    localparam logic [31:0] EVM  = 32'h4FCF_8000;
    localparam logic [31:0] IMPL = 32'h7FCF_8000;
    localparam logic [31:0] HARD = 32'h2000_0000;

    always #4 clk = ~clk;

    debug_event_status uut (
        .clk(clk), .rst_n(rst_n), .hard_rst_i(hard),
        .ev_insn_i(evs[0]), .ev_branch_i(evs[1]), .ev_intr_i(evs[2]), .ev_trap_i(evs[3]),
        .ev_imatch0_i(evs[4]), .ev_imatch1_i(evs[5]), .ev_drd0_i(evs[6]), .ev_dwr0_i(evs[7]),
        .ev_drd1_i(evs[8]), .ev_dwr1_i(evs[9]), .ev_return_i(evs[10]),
        .uncond_dbg_n_i(ud_n), .dbg_en_i(den), .int_mode_i(imode),
        .wr_en_i(wen), .wr_be_i(be), .wr_data_i(wd),
        .rd_data_o(rd), .dbg_irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic w1c(input logic [3:0] lanes, input logic [31:0] data);
        wen = 1'b1; be = lanes; wd = data;
        tick();
        wen = 1'b0; be = '0; wd = '0;
    endtask

    function automatic logic [31:0] lane_bits(input logic [3:0] lanes);
        logic [31:0] m = '0;
        for (int l = 0; l < 4; l++) if (lanes[l]) m |= 32'hFF << (8 * l);
        return m;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        logic [31:0] exp;
        logic [31:0] cause;
        tick(); tick(); tick();
        rst_n = 1'b1; hard = 1'b0;
        tick();
        // R1 / R9: after hard reset, flags clear and cause reads 10
        chk("R1 reset flags", rd & EVM, 32'h0);
        chk("R9 hard reset cause", rd, HARD);
        chk("R8 irq idle", {31'b0, irq}, 32'h0);

        // R2 / R3 / R4 / R8: sweep every pulse event
        for (int e = 0; e < 11; e++) begin
            evs = 11'(1) << e;
            tick();
            evs = '0;
            chk($sformatf("R2 event %0d set", e), rd, HARD | (32'h1 << POS[e]));
            chk("R8 irq off without enable", {31'b0, irq}, 32'h0);
            den = 1'b1; #1;
            chk("R8 irq with enable", {31'b0, irq}, 32'h1);
            den = 1'b0;
            tick(); tick();
            chk("R3 flag sticky", rd, HARD | (32'h1 << POS[e]));
            w1c(4'hF, 32'h0);
            chk("R4 zero write no effect", rd, HARD | (32'h1 << POS[e]));
            w1c(4'hF, 32'h1 << POS[e]);
            chk("R4 w1c clears", rd, HARD);
        end

        // R6 / R7 / R8: all mode combinations of the unconditional request
        for (int c = 0; c < 4; c++) begin
            imode = c[0]; den = c[1];
            ud_n = 1'b0;
            tick(); tick();
            ud_n = 1'b1;
            chk(c[0] ? "R7 uncond sets" : "R6 uncond ignored", rd, HARD | (c[0] ? 32'h4000_0000 : 32'h0));
            chk("R8 irq from uncond", {31'b0, irq}, {31'b0, c[0] & c[1]});
            w1c(4'hF, 32'h4000_0000);
            chk("R4 uncond cleared", rd, HARD);
            imode = 1'b0; den = 1'b0;
        end

        // R3: set and clear of the same flag in one cycle, set wins
        evs[0] = 1'b1; wen = 1'b1; be = 4'hF; wd = 32'h0800_0000;
        tick();
        evs = '0; wen = 1'b0; be = '0; wd = '0;
        chk("R3 set beats clear", rd, HARD | 32'h0800_0000);
        w1c(4'hF, 32'h0800_0000);

        // R5: writes to reserved bits have no effect and they read zero
        evs = '1; tick(); evs = '0;
        w1c(4'hF, ~IMPL);
        chk("R5 reserved ignore write", rd, HARD | (EVM & ~32'h4000_0000));
        chk("R5 reserved read zero", rd & ~IMPL, 32'h0);

        // R4 / R9: byte-lane sweep, refill before each pattern
        cause = HARD;
        for (int b = 0; b < 16; b++) begin
            evs = '1; ud_n = 1'b0; imode = 1'b1;
            tick();
            evs = '0; ud_n = 1'b1; imode = 1'b0;
            w1c(4'(b), 32'hFFFF_FFFF);
            exp = ((EVM | cause) & ~lane_bits(4'(b)));
            cause = cause & ~lane_bits(4'(b));
            chk($sformatf("R4 lanes %0h", b), rd, exp);
            chk("R5 reserved after lanes", rd & ~IMPL, 32'h0);
        end
        w1c(4'hF, 32'hFFFF_FFFF);
        chk("R9 cause cleared by w1c", rd, 32'h0);

        // R9 / R1: soft reset with cause clear, then hard, then soft
        evs = '1; rst_n = 1'b0; hard = 1'b0;
        tick();
        evs = '0; rst_n = 1'b1;
        chk("R1 pulses ignored in reset", rd, 32'h0);
        rst_n = 1'b0; hard = 1'b1; tick(); rst_n = 1'b1; hard = 1'b0;
        chk("R9 hard reset again", rd, HARD);
        evs = '1; tick(); evs = '0;
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R9 soft reset keeps hard bit", rd, HARD);
        chk("R1 soft reset clears flags", rd & EVM, 32'h0);
        w1c(4'h8, HARD);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R9 soft reset after clear", rd, 32'h0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual running expected done");
            summary();
            $finish;
        end
    end
endmodule